// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port and produces the event notification that goes with them. Software reaches both registers through one 16-bit read/write port with two byte lanes. The slot side reports three kinds of request: a device present at power-up, a hot insertion and a hot removal. It also reports attention button presses. The block records these as event bits that software clears by writing 1. It also emulates an electromechanical interlock: software toggles the interlock, and while it is engaged the block refuses insertion and removal requests.

A notify condition is formed from the interrupt enable, the three event bits and their per-event enables. Each time that condition changes value, the block issues one notification. If MSI-X is enabled it sends an MSI-X request pulse. Otherwise, if MSI is enabled, it sends an MSI request pulse. If neither is enabled, it drives the selected INTx line to the new condition level. Every control write counts as a completed command and raises the command-completed event in the same cycle.

Register map. `reg_sel_i` = 0 selects the control register and 1 selects the status register. Byte lane 0 covers bits [7:0] and byte lane 1 covers bits [15:8].

Control register bits: [0] attention button enable, [1] presence change enable, [2] command done enable, [3] hot-plug interrupt enable, [5:4] attention indicator, [7:6] power indicator, [8] interlock toggle. All other bits read 0.

Status register bits: [0] attention button event, [1] presence change event, [2] command done event, [8] device present, [9] interlock engaged. All other bits read 0.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the control register reads 0x00F0, with both indicator fields at 2'b11 (off) and every enable clear. The status register reads 0x0000. No notification output is active.
- R2: A control write with byte lane 0 enabled loads bits [7:0]. A control write with only byte lane 1 enabled leaves bits [7:0] unchanged. Bits [15:9] always read 0.
- R3: A control write with at least one byte enable set sets status bit 2 (command done), even if it changes no value. A control write with both byte enables clear has no effect at all.
- R4: A control write with byte lane 1 enabled and bit 8 set toggles status bit 9 (interlock engaged). Control bit 8 always reads 0.
- R5: A status write with byte lane 0 enabled clears each of status bits [2:0] whose write-data bit is 1. Writes have no effect on status bits 8 and 9.
- R6: If the slot side sets an event bit in the same cycle that software clears it, the bit stays set.
- R7: The notify condition is true when control bit 3 is set and at least one of status bits [2:0] is set together with its enable at the same index in control bits [2:0].
- R8: One notification is issued in the cycle after each change of the notify condition. Setting an event bit that is already set, or doing anything else that leaves the condition unchanged, issues none.
- R9: A notification is a one-cycle pulse on `msix_req_o` when `msix_en_i` is 1, else a pulse on `msi_req_o` when `msi_en_i` is 1. When a pulse is sent, `msg_vec_o` takes the value of `msg_num_i`.
- R10: When neither message mode is enabled, a notification drives line `intx_sel_i` of `intx_o` to the new condition level. All other INTx lines keep their level. While a message mode is enabled, `intx_o` holds.
- R11: An insertion or removal request made while the interlock is engaged raises `plug_busy_o` in the same cycle and changes neither presence nor any event bit.
- R12: A power-up presence report sets status bit 8 without setting status bit 1. An accepted insertion sets bit 8 and bit 1. An accepted removal clears bit 8 and sets bit 1. If insertion and removal are requested together, the insertion wins.
- R13: An attention button press sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 1 | 0 selects the control register, 1 selects the status register |
| wr_en_i | input | 1 | Write strobe |
| byte_en_i | input | 2 | Byte lane enables for the write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| attn_btn_i | input | 1 | Attention button press pulse |
| cold_present_i | input | 1 | Device present at power-up (no event) |
| insert_req_i | input | 1 | Hot insertion request pulse |
| remove_req_i | input | 1 | Hot removal request pulse |
| plug_busy_o | output | 1 | Request refused because the interlock is engaged |
| msix_en_i | input | 1 | MSI-X mode enabled |
| msi_en_i | input | 1 | MSI mode enabled |
| msg_num_i | input | VEC_W | Interrupt message number |
| intx_sel_i | input | SEL_W | Selected INTx line |
| msix_req_o | output | 1 | MSI-X notification pulse |
| msi_req_o | output | 1 | MSI notification pulse |
| msg_vec_o | output | VEC_W | Vector of the last message sent |
| intx_o | output | NUM_INTX | INTx line levels |

## Verification
The bench builds the block with NUM_INTX = 4 and VEC_W = 5. With four lines, the bench can route the condition to line 2 and check that lines 0, 1 and 3 never move. The 5-bit vector lets the bench send distinct values, such as 19 and 31, and tell them apart on `msg_vec_o`. With these sizes the bench covers every path of the priority between MSI-X, MSI and INTx. It also covers interlock refusal, the case where set and clear land in the same cycle, and both edges of the notify condition.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W       = 16;
  localparam int N_EVT       = 3;
  // control register bit positions
  localparam int CTL_LOCK_TGL = 8;
  // status register bit positions
  localparam int ST_ABP  = 0;
  localparam int ST_PDC  = 1;
  localparam int ST_CC   = 2;
  localparam int ST_PRES = 8;
  localparam int ST_LOCK = 9;
  localparam logic [1:0] IND_OFF = 2'b11;

  // packed to match control bits [7:0]
  typedef struct packed {
    logic [1:0] pwr_ind;
    logic [1:0] attn_ind;
    logic       hp_int_en;
    logic       cc_en;
    logic       pdc_en;
    logic       abp_en;
  } slot_ctl_t;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_STS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/hp_slot_ctl_reg.sv
module hp_slot_ctl_reg
  import hp_slot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       be_i,
  input  logic [REG_W-1:0] wdata_i,
  output slot_ctl_t        ctl_o,
  output logic             cmd_o,
  output logic             lock_tgl_o
);
  slot_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '{pwr_ind: IND_OFF, attn_ind: IND_OFF, default: 1'b0};
    end else if (wr_i && be_i[0]) begin
      ctl_q <= slot_ctl_t'(wdata_i[7:0]);
    end
  end

  // any touched byte is one command
  assign cmd_o      = wr_i && (be_i != 2'b00);
  assign lock_tgl_o = wr_i && be_i[1] && wdata_i[CTL_LOCK_TGL];
  assign ctl_o      = ctl_q;
endmodule

// File: rtl/hp_slot_sts_reg.sv
module hp_slot_sts_reg
  import hp_slot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       be_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             cmd_i,
  input  logic             lock_tgl_i,
  input  logic             attn_btn_i,
  input  logic             cold_i,
  input  logic             ins_i,
  input  logic             rem_i,
  output logic [N_EVT-1:0] evt_o,
  output logic             present_o,
  output logic             lock_o,
  output logic             busy_o
);
  logic [N_EVT-1:0] evt_q, evt_set, evt_clr;
  logic             pres_q, lock_q;
  logic             ins_ok, rem_ok;

  assign busy_o = (ins_i || rem_i) && lock_q;
  assign ins_ok = ins_i && !lock_q;
  assign rem_ok = rem_i && !lock_q && !ins_i;

  always_comb begin
    evt_set         = '0;
    evt_set[ST_ABP] = attn_btn_i;
    evt_set[ST_PDC] = ins_ok || rem_ok;
    evt_set[ST_CC]  = cmd_i;
    evt_clr         = (wr_i && be_i[0]) ? wdata_i[N_EVT-1:0] : '0;
  end

  // set wins over a same-cycle clear
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q[g] <= 1'b0;
      else         evt_q[g] <= evt_set[g] || (evt_q[g] && !evt_clr[g]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (ins_ok || cold_i) pres_q <= 1'b1;
      else if (rem_ok)      pres_q <= 1'b0;
      if (lock_tgl_i)       lock_q <= !lock_q;
    end
  end

  assign evt_o     = evt_q;
  assign present_o = pres_q;
  assign lock_o    = lock_q;
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int NUM_INTX = 4,
  parameter int VEC_W    = 5,
  localparam int SEL_W   = (NUM_INTX > 1) ? $clog2(NUM_INTX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  slot_ctl_t           ctl_i,
  input  logic [N_EVT-1:0]    evt_i,
  input  logic                msix_en_i,
  input  logic                msi_en_i,
  input  logic [VEC_W-1:0]    vec_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                msix_o,
  output logic                msi_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic [NUM_INTX-1:0] intx_o
);
  logic [N_EVT-1:0] evt_en;
  logic cond, notify_q, chg, to_line;
  logic msix_q, msi_q;
  logic [VEC_W-1:0] vec_q;
  logic [NUM_INTX-1:0] intx_q;

  assign evt_en  = {ctl_i.cc_en, ctl_i.pdc_en, ctl_i.abp_en};
  assign cond    = ctl_i.hp_int_en && |(evt_i & evt_en);
  assign chg     = cond ^ notify_q;
  assign to_line = chg && !msix_en_i && !msi_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_q <= 1'b0;
      msix_q   <= 1'b0;
      msi_q    <= 1'b0;
      vec_q    <= '0;
    end else begin
      notify_q <= cond;
      msix_q   <= chg && msix_en_i;
      msi_q    <= chg && !msix_en_i && msi_en_i;
      if (chg && (msix_en_i || msi_en_i)) vec_q <= vec_i;
    end
  end

  for (genvar g = 0; g < NUM_INTX; g++) begin : g_intx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              intx_q[g] <= 1'b0;
      else if (to_line && sel_i == SEL_W'(g))   intx_q[g] <= cond;
    end
  end

  assign msix_o = msix_q;
  assign msi_o  = msi_q;
  assign vec_o  = vec_q;
  assign intx_o = intx_q;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int NUM_INTX = 4,
  parameter int VEC_W    = 5,
  localparam int SEL_W   = (NUM_INTX > 1) ? $clog2(NUM_INTX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_sel_i,
  input  logic                wr_en_i,
  input  logic [1:0]          byte_en_i,
  input  logic [15:0]         wdata_i,
  output logic [15:0]         rdata_o,
  input  logic                attn_btn_i,
  input  logic                cold_present_i,
  input  logic                insert_req_i,
  input  logic                remove_req_i,
  output logic                plug_busy_o,
  input  logic                msix_en_i,
  input  logic                msi_en_i,
  input  logic [VEC_W-1:0]    msg_num_i,
  input  logic [SEL_W-1:0]    intx_sel_i,
  output logic                msix_req_o,
  output logic                msi_req_o,
  output logic [VEC_W-1:0]    msg_vec_o,
  output logic [NUM_INTX-1:0] intx_o
);
  slot_ctl_t        ctl_w;
  logic             ctl_wr, sts_wr, cmd_w, tgl_w;
  logic [N_EVT-1:0] evt_w;
  logic             pres_w, lock_w;

  assign ctl_wr = wr_en_i && (reg_sel_e'(reg_sel_i) == SEL_CTL);
  assign sts_wr = wr_en_i && (reg_sel_e'(reg_sel_i) == SEL_STS);

  hp_slot_ctl_reg u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctl_wr),
    .be_i       (byte_en_i),
    .wdata_i    (wdata_i),
    .ctl_o      (ctl_w),
    .cmd_o      (cmd_w),
    .lock_tgl_o (tgl_w)
  );

  hp_slot_sts_reg u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (sts_wr),
    .be_i       (byte_en_i),
    .wdata_i    (wdata_i),
    .cmd_i      (cmd_w),
    .lock_tgl_i (tgl_w),
    .attn_btn_i (attn_btn_i),
    .cold_i     (cold_present_i),
    .ins_i      (insert_req_i),
    .rem_i      (remove_req_i),
    .evt_o      (evt_w),
    .present_o  (pres_w),
    .lock_o     (lock_w),
    .busy_o     (plug_busy_o)
  );

  hp_slot_notify #(.NUM_INTX(NUM_INTX), .VEC_W(VEC_W)) u_ntf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl_w),
    .evt_i     (evt_w),
    .msix_en_i (msix_en_i),
    .msi_en_i  (msi_en_i),
    .vec_i     (msg_num_i),
    .sel_i     (intx_sel_i),
    .msix_o    (msix_req_o),
    .msi_o     (msi_req_o),
    .vec_o     (msg_vec_o),
    .intx_o    (intx_o)
  );

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(reg_sel_i) == SEL_CTL) begin
      rdata_o[7:0] = ctl_w;
    end else begin
      rdata_o[N_EVT-1:0] = evt_w;
      rdata_o[ST_PRES]   = pres_w;
      rdata_o[ST_LOCK]   = lock_w;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
  parameter int NUM_INTX = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_sel_i,
  input logic                wr_en_i,
  input logic [1:0]          byte_en_i,
  input logic [15:0]         wdata_i,
  input logic [15:0]         rdata_o,
  input logic                attn_btn_i,
  input logic                plug_busy_o,
  input logic                msix_en_i,
  input logic                msi_en_i,
  input logic                msix_req_o,
  input logic                msi_req_o,
  input logic [NUM_INTX-1:0] intx_o,
  input logic [2:0]          sts_evt,
  input logic                sts_pres,
  input logic                sts_lock
);
  assert_cmd_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i && byte_en_i != 2'b00) |=> sts_evt[2]);

  assert_lock_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i && byte_en_i[1] && wdata_i[8]) |=> (sts_lock != $past(sts_lock)));

  assert_lock_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> !rdata_o[8]);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_btn_i |=> sts_evt[0]);

  assert_one_route_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msix_req_o && msi_req_o));

  assert_intx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msix_en_i || msi_en_i) |=> $stable(intx_o));

  assert_busy_keeps_presence_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plug_busy_o |=> $stable(sts_pres));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.NUM_INTX(NUM_INTX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_sel_i   (reg_sel_i),
  .wr_en_i     (wr_en_i),
  .byte_en_i   (byte_en_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .attn_btn_i  (attn_btn_i),
  .plug_busy_o (plug_busy_o),
  .msix_en_i   (msix_en_i),
  .msi_en_i    (msi_en_i),
  .msix_req_o  (msix_req_o),
  .msi_req_o   (msi_req_o),
  .intx_o      (intx_o),
  .sts_evt     (evt_w),
  .sts_pres    (pres_w),
  .sts_lock    (lock_w)
);

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
  localparam int NUM_INTX = 4;
  localparam int VEC_W    = 5;
  localparam int SEL_W    = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, wr_en = 1'b0;
  logic [1:0] be = 2'b00;
  logic [15:0] wdata = 16'h0;
  logic attn = 1'b0, cold = 1'b0, ins = 1'b0, rem = 1'b0;
  logic msix_en = 1'b0, msi_en = 1'b0;
  logic [VEC_W-1:0] msg_num = '0;
  logic [SEL_W-1:0] sel = 2'd2;
  logic [15:0] rdata;
  logic busy, msix_req, msi_req;
  logic [VEC_W-1:0] vec;
  logic [NUM_INTX-1:0] intx;

  int checks = 0, errors = 0, n_msix = 0, n_msi = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hp_slot_ctrl #(.NUM_INTX(NUM_INTX), .VEC_W(VEC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .wr_en_i(wr_en),
    .byte_en_i(be), .wdata_i(wdata), .rdata_o(rdata), .attn_btn_i(attn),
    .cold_present_i(cold), .insert_req_i(ins), .remove_req_i(rem),
    .plug_busy_o(busy), .msix_en_i(msix_en), .msi_en_i(msi_en),
    .msg_num_i(msg_num), .intx_sel_i(sel), .msix_req_o(msix_req),
    .msi_req_o(msi_req), .msg_vec_o(vec), .intx_o(intx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced at each rising edge
  logic [7:0] m_ctl;
  logic [2:0] m_evt;
  logic m_pres, m_lock, m_cond_q, m_msix, m_msi;
  logic [VEC_W-1:0] m_vec;
  logic [NUM_INTX-1:0] m_intx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 8'hF0; m_evt = 3'b0; m_pres = 0; m_lock = 0; m_cond_q = 0;
      m_msix = 0; m_msi = 0; m_vec = '0; m_intx = '0;
    end else begin
      bit cond, cmd, ok_ins, ok_rem;
      cond = m_ctl[3] && ((m_evt & m_ctl[2:0]) != 3'b0);
      m_msix = 0; m_msi = 0;
      if (cond != m_cond_q) begin
        if (msix_en) begin m_msix = 1; m_vec = msg_num; end
        else if (msi_en) begin m_msi = 1; m_vec = msg_num; end
        else m_intx[sel] = cond;
      end
      m_cond_q = cond;
      cmd = wr_en && !reg_sel && be != 2'b00;
      ok_ins = ins && !m_lock;
      ok_rem = rem && !m_lock && !ins;
      if (wr_en && reg_sel && be[0]) m_evt = m_evt & ~wdata[2:0];
      if (attn) m_evt[0] = 1;
      if (ok_ins || ok_rem) m_evt[1] = 1;
      if (cmd) m_evt[2] = 1;
      if (wr_en && !reg_sel && be[0]) m_ctl = wdata[7:0];
      if (ok_ins || cold) m_pres = 1; else if (ok_rem) m_pres = 0;
      if (cmd && be[1] && wdata[8]) m_lock = !m_lock;
    end
  end

  // compare on every clock, mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 rdata", rdata, reg_sel ? {6'b0, m_lock, m_pres, 5'b0, m_evt} : {8'h00, m_ctl});
      chk("R9 msix_req", msix_req, m_msix);
      chk("R9 msi_req", msi_req, m_msi);
      chk("R9 msg_vec", vec, m_vec);
      chk("R10 intx", intx, m_intx);
      chk("R11 busy", busy, (ins || rem) && m_lock);
      if (msix_req) n_msix++;
      if (msi_req) n_msi++;
    end
  end

  task automatic step; @(posedge clk); #1; endtask
  task automatic settle; step; step; endtask

  task automatic wr(input logic s, input logic [1:0] b, input logic [15:0] d);
    reg_sel = s; wr_en = 1; be = b; wdata = d;
    step;
    wr_en = 0; be = 2'b00; wdata = 16'h0;
  endtask

  task automatic rd(input logic s, output logic [15:0] v);
    reg_sel = s; #1; v = rdata;
  endtask

  initial begin
    logic [15:0] v;
    int c0;
    repeat (3) @(posedge clk);
    #1;
    rd(0, v); chk("R1 ctl reset", v, 16'h00F0);
    rd(1, v); chk("R1 sts reset", v, 16'h0000);
    chk("R1 outputs reset", {msix_req, msi_req, intx}, 0);
    rst_n = 1;
    step;

    // R12 power-up presence: no change event
    cold = 1; step; cold = 0;
    rd(1, v); chk("R12 cold present", v, 16'h0100);

    // R2/R3/R7 enable all, command done raises condition, INTx line 2
    wr(0, 2'b01, 16'h000F);
    rd(0, v); chk("R2 ctl write", v, 16'h000F);
    rd(1, v); chk("R3 cmd done", v, 16'h0104);
    settle;
    chk("R10 intx line 2 up", intx, 4'b0100);

    // R8 repeat command: event already set, no change
    c0 = n_msix + n_msi;
    wr(0, 2'b01, 16'h000F); settle;
    chk("R8 no renotify intx", intx, 4'b0100);
    chk("R8 no renotify msg", n_msix + n_msi, c0);

    // R5 clear command done, presence/lock not writable
    wr(1, 2'b11, 16'h0304);
    rd(1, v); chk("R5 w1c", v, 16'h0100);
    settle;
    chk("R10 intx line 2 down", intx, 4'b0000);

    // R13/R9 MSI-X path
    msix_en = 1; msg_num = 5'd19;
    attn = 1; step; attn = 0;
    rd(1, v); chk("R13 attn evt", v, 16'h0101);
    settle;
    chk("R9 msix count", n_msix, 1);
    chk("R9 vector", vec, 19);
    chk("R10 intx hold", intx, 4'b0000);

    // R9 MSI-X wins over MSI on the falling change
    msi_en = 1; msg_num = 5'd31;
    wr(1, 2'b01, 16'h0001); settle;
    chk("R9 msix priority", n_msix, 2);
    chk("R9 no msi", n_msi, 0);
    chk("R9 vector 31", vec, 31);

    // R9 MSI only
    msix_en = 0; msg_num = 5'd7;
    attn = 1; step; attn = 0; settle;
    chk("R9 msi count", n_msi, 1);
    chk("R9 msi vector", vec, 7);

    // R4 lock toggle via lane 1 only; R2 low byte kept
    wr(0, 2'b10, 16'h01FF);
    rd(0, v); chk("R4 ctl bit8 reads 0", v, 16'h000F);
    rd(1, v); chk("R4 lock engaged", v, 16'h0305);

    // R11 insertion refused while locked
    wr(1, 2'b01, 16'h0007); settle;
    ins = 1; #1; chk("R11 busy", busy, 1); step; ins = 0;
    rd(1, v); chk("R11 no change", v, 16'h0300);
    rem = 1; #1; chk("R11 busy rem", busy, 1); step; rem = 0;
    rd(1, v); chk("R11 no change rem", v, 16'h0300);

    // release lock, R12 removal and insertion
    wr(0, 2'b10, 16'h0100);
    wr(1, 2'b01, 16'h0004);
    rd(1, v); chk("R4 lock released", v, 16'h0100);
    rem = 1; step; rem = 0;
    rd(1, v); chk("R12 removal", v, 16'h0002);
    wr(1, 2'b01, 16'h0002);
    ins = 1; rem = 1; step; ins = 0; rem = 0;
    rd(1, v); chk("R12 insertion wins", v, 16'h0102);

    // R6 set and clear in the same cycle
    wr(1, 2'b01, 16'h0007);
    attn = 1; reg_sel = 1; wr_en = 1; be = 2'b01; wdata = 16'h0001;
    step;
    attn = 0; wr_en = 0; be = 2'b00; wdata = 16'h0;
    rd(1, v); chk("R6 set wins", v, 16'h0101);

    // R3 no byte enable: no command
    wr(1, 2'b01, 16'h0007);
    msi_en = 0; settle;
    wr(0, 2'b00, 16'h01FF);
    rd(1, v); chk("R3 be0 no cmd", v, 16'h0100);
    rd(0, v); chk("R3 be0 no write", v, 16'h000F);

    // R7 interrupt enable off masks condition
    wr(0, 2'b01, 16'h0007); settle;
    chk("R7 hpie off", intx, 4'b0000);
    wr(0, 2'b01, 16'h000F); settle;
    chk("R7 hpie on", intx, 4'b0100);
    repeat (4) step;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule